// File: doc/BRIEF.md
# Boot-Remap Master Address Decoder

This block turns one bus master's address into a slave select inside a multi-layer interconnect. Each master gets its own copy, so the results for one master never depend on another. Each accepted address produces either a one-hot slave select or a decode-error flag, one clock cycle later.

The lowest window of the address space, called the boot window, has no fixed owner. After reset it points at internal boot ROM or at external boot memory. Which of the two is decided by a boot-mode pin that is sampled while reset is held. Software can later issue a remap command that places internal SRAM in that window, so the exception vectors become writable. A clear command undoes the remap.

Every address outside the boot window is looked up in a small parameterized region table. The result of that lookup does not depend on the remap state.

Top module: `boot_remap_decoder`

## Requirements
- R1: With remap clear and the captured boot pin at 0, an address inside the boot window (addr[31:20] == 0) selects slave 0 (internal boot ROM), including the top word 0x000F_FFFC.
- R2: With remap clear and the captured boot pin at 1, a boot-window address selects slave 1 (external boot memory).
- R3: The boot pin value is the one present at the last rising clock edge with reset high. Changes to the pin after reset releases have no effect on decoding until the next reset.
- R4: Once remap is set, a boot-window address selects slave 2 (internal SRAM), whatever the boot pin.
- R5: A remap-clear pulse returns the boot window to the boot memory. Clear wins when set and clear arrive in the same cycle. Reset also clears remap.
- R6: Outside the boot window, addresses decode by the fixed default table, in both remap states:
  - 0x0010_0000–0x001F_FFFF selects slave 0.
  - 0x0020_0000–0x002F_FFFF selects slave 2.
  - 0x1000_0000–0x1FFF_FFFF selects slave 1.
  - 0xF000_0000–0xFFFF_FFFF selects slave 3.
- R7: When table entries overlap, the lowest-numbered entry wins. The 4 KiB entry at 0x1000_0000 (slave 4) takes precedence over the larger entry that also covers it (slave 1).
- R8: An address that hits neither the boot window nor any table entry raises err_o and drives sel_o to all zeros.
- R9: sel_o and err_o are registered: the result for an address with valid_i high appears after the next rising edge. A cycle with valid_i low gives sel_o = 0 and err_o = 0. sel_o never has more than one bit set. Both outputs are 0 during and right after reset.
- R10: A decode in the same cycle as a remap set uses the remap state from before that cycle. The new state applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| boot_ext_i | input | 1 | Boot-mode pin: 1 = external boot memory, 0 = internal boot ROM |
| remap_set_i | input | 1 | Pulse that places SRAM in the boot window |
| remap_clr_i | input | 1 | Pulse that returns the boot window to boot memory |
| valid_i | input | 1 | Address strobe |
| addr_i | input | ADDR_W | Master address |
| sel_o | output | N_SLAVES | Registered one-hot slave select |
| err_o | output | 1 | Registered decode-error flag |

## Verification
The bench flips the boot pin in the very cycle reset releases. A design that keeps tracking the pin would then send boot-window accesses to the wrong boot memory.

It issues a boot-window decode in the same cycle as a remap set, and it drives set and clear together. A design that forwards the command into the decode would answer with SRAM one access too early. A design that gives set the priority would leave SRAM mapped after the combined pulse.

It also probes the following, each of which exposes a specific fault:
- The top word of the boot window, which exposes an off-by-one window size.
- Addresses in the overlapping table entries, which expose a reversed priority.
- Two unmapped holes, which would show up as a spurious select instead of an error.

// File: rtl/brd_pkg.sv
package brd_pkg;
  typedef enum logic [1:0] {
    SRC_INT_ROM = 2'd0,
    SRC_EXT_MEM = 2'd1,
    SRC_SRAM    = 2'd2
  } boot_src_e;
endpackage

// File: rtl/boot_remap_state.sv
module boot_remap_state
  import brd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_i,
  input  logic      boot_ext_i,
  input  logic      remap_set_i,
  input  logic      remap_clr_i,
  output logic      remap_q,
  output logic      boot_ext_q,
  output boot_src_e src_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      remap_q    <= 1'b0;
      boot_ext_q <= boot_ext_i;
    end else if (remap_clr_i) begin
      remap_q <= 1'b0;
    end else if (remap_set_i) begin
      remap_q <= 1'b1;
    end
  end

  always_comb begin
    if (remap_q)         src_o = SRC_SRAM;
    else if (boot_ext_q) src_o = SRC_EXT_MEM;
    else                 src_o = SRC_INT_ROM;
  end
endmodule

// File: rtl/region_table_match.sv
module region_table_match #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned N_REGIONS = 5,
  parameter int unsigned SLV_W     = 3,
  parameter logic [N_REGIONS*ADDR_W-1:0] REG_BASE  = '0,
  parameter logic [N_REGIONS*8-1:0]      REG_LOG2  = '0,
  parameter logic [N_REGIONS*8-1:0]      REG_SLAVE = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [SLV_W-1:0]  slave_o
);
  logic [N_REGIONS-1:0] hit;
  logic [SLV_W-1:0]     slv_tab [N_REGIONS];

  for (genvar g = 0; g < N_REGIONS; g++) begin : g_entry
    localparam int unsigned        LG   = int'(REG_LOG2[g*8 +: 8]);
    localparam logic [ADDR_W-1:0]  BASE = REG_BASE[g*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0]  MASK = {ADDR_W{1'b1}} << LG;
    assign hit[g]     = ((addr_i ^ BASE) & MASK) == '0;
    assign slv_tab[g] = REG_SLAVE[g*8 +: SLV_W];
  end

  // lowest index has priority: scan downward so it is written last
  always_comb begin
    hit_o   = 1'b0;
    slave_o = '0;
    for (int i = N_REGIONS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        hit_o   = 1'b1;
        slave_o = slv_tab[i];
      end
    end
  end
endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
  import brd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned N_SLAVES  = 8,
  parameter int unsigned BOOT_LOG2 = 20,
  parameter int unsigned SLV_INT   = 0,
  parameter int unsigned SLV_EXT   = 1,
  parameter int unsigned SLV_SRAM  = 2,
  parameter int unsigned N_REGIONS = 5,
  parameter logic [N_REGIONS*ADDR_W-1:0] REG_BASE =
    {32'hF000_0000, 32'h1000_0000, 32'h1000_0000, 32'h0020_0000, 32'h0010_0000},
  parameter logic [N_REGIONS*8-1:0] REG_LOG2  = {8'd28, 8'd28, 8'd12, 8'd20, 8'd20},
  parameter logic [N_REGIONS*8-1:0] REG_SLAVE = {8'd3, 8'd1, 8'd4, 8'd2, 8'd0}
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                boot_ext_i,
  input  logic                remap_set_i,
  input  logic                remap_clr_i,
  input  logic                valid_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [N_SLAVES-1:0] sel_o,
  output logic                err_o
);
  localparam int unsigned SLV_W = (N_SLAVES > 1) ? $clog2(N_SLAVES) : 1;

  logic       remap_q;
  logic       boot_ext_q;
  boot_src_e  src;

  boot_remap_state u_state (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .boot_ext_i (boot_ext_i),
    .remap_set_i(remap_set_i),
    .remap_clr_i(remap_clr_i),
    .remap_q    (remap_q),
    .boot_ext_q (boot_ext_q),
    .src_o      (src)
  );

  logic             tab_hit;
  logic [SLV_W-1:0] tab_slave;

  region_table_match #(
    .ADDR_W   (ADDR_W),
    .N_REGIONS(N_REGIONS),
    .SLV_W    (SLV_W),
    .REG_BASE (REG_BASE),
    .REG_LOG2 (REG_LOG2),
    .REG_SLAVE(REG_SLAVE)
  ) u_table (
    .addr_i (addr_i),
    .hit_o  (tab_hit),
    .slave_o(tab_slave)
  );

  logic                boot_hit;
  logic [SLV_W-1:0]    boot_slave;
  logic [SLV_W-1:0]    tgt;
  logic                miss;
  logic [N_SLAVES-1:0] sel_d;

  assign boot_hit = addr_i[ADDR_W-1:BOOT_LOG2] == '0;

  always_comb begin
    unique case (src)
      SRC_SRAM:    boot_slave = SLV_W'(SLV_SRAM);
      SRC_EXT_MEM: boot_slave = SLV_W'(SLV_EXT);
      default:     boot_slave = SLV_W'(SLV_INT);
    endcase
  end

  assign tgt  = boot_hit ? boot_slave : tab_slave;
  assign miss = !boot_hit && !tab_hit;

  always_comb begin
    sel_d = '0;
    if (valid_i && !miss) sel_d[tgt] = 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sel_o <= '0;
      err_o <= 1'b0;
    end else begin
      sel_o <= sel_d;
      err_o <= valid_i && miss;
    end
  end
endmodule

// File: rtl/brd_checker.sv
module brd_checker #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned N_SLAVES  = 8,
  parameter int unsigned BOOT_LOG2 = 20,
  parameter int unsigned SLV_SRAM  = 2
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic                valid_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                remap_set_i,
  input logic                remap_clr_i,
  input logic [N_SLAVES-1:0] sel_o,
  input logic                err_o,
  input logic                remap_q,
  input logic                boot_ext_q
);
  a_r9_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(sel_o));

  a_r8_err_no_sel: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |-> sel_o == '0);

  a_r9_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_i |=> (sel_o == '0 && !err_o));

  a_r9_answer: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_i |=> (sel_o != '0 || err_o));

  a_r5_clear_wins: assert property (@(posedge clk_i) disable iff (rst_i)
    remap_clr_i |=> !remap_q);

  a_r4_set: assert property (@(posedge clk_i) disable iff (rst_i)
    (remap_set_i && !remap_clr_i) |=> remap_q);

  a_r3_pin_held: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> $stable(boot_ext_q));

  a_r4_sram_select: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_i && remap_q && addr_i[ADDR_W-1:BOOT_LOG2] == '0) |=> sel_o[SLV_SRAM]);
endmodule

bind boot_remap_decoder brd_checker #(
  .ADDR_W   (ADDR_W),
  .N_SLAVES (N_SLAVES),
  .BOOT_LOG2(BOOT_LOG2),
  .SLV_SRAM (SLV_SRAM)
) chk_i (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .valid_i    (valid_i),
  .addr_i     (addr_i),
  .remap_set_i(remap_set_i),
  .remap_clr_i(remap_clr_i),
  .sel_o      (sel_o),
  .err_o      (err_o),
  .remap_q    (remap_q),
  .boot_ext_q (boot_ext_q)
);

// File: tb/boot_remap_decoder_tb_top.sv
module boot_remap_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] sel;
    logic       err;
    string      tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_i = 1'b1;
  logic        boot_ext_i = 1'b0;
  logic        remap_set_i = 1'b0;
  logic        remap_clr_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [7:0]  sel_o;
  logic        err_o;

  int   n_checks = 0;
  int   n_fail   = 0;
  exp_t sb_q[$];
  logic m_remap = 1'b0;
  logic m_ext   = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  boot_remap_decoder dut_i (
    .clk_i(clk_i), .rst_i(rst_i), .boot_ext_i(boot_ext_i),
    .remap_set_i(remap_set_i), .remap_clr_i(remap_clr_i),
    .valid_i(valid_i), .addr_i(addr_i), .sel_o(sel_o), .err_o(err_o)
  );

  // expected slave index from the requirements; -1 means decode error
  function automatic int model_target(logic [31:0] a);
    if (a[31:20] == 12'h000) return m_remap ? 2 : (m_ext ? 1 : 0); // R1 R2 R4
    if (a[31:20] == 12'h001) return 0;                             // R6
    if (a[31:20] == 12'h002) return 2;                             // R6
    if (a[31:12] == 20'h10000) return 4;                           // R7
    if (a[31:28] == 4'h1) return 1;                                // R6
    if (a[31:28] == 4'hF) return 3;                                // R6
    return -1;                                                     // R8
  endfunction

  task automatic cycle(input logic v, input logic [31:0] a,
                       input logic set, input logic clr, input string tag);
    exp_t e;
    int   t;
    @(negedge clk_i);
    valid_i = v; addr_i = a; remap_set_i = set; remap_clr_i = clr;
    t = model_target(a);
    e.sel = '0;
    e.err = 1'b0;
    if (v) begin
      if (t < 0) e.err = 1'b1;
      else       e.sel[t] = 1'b1;
    end
    e.tag = tag;
    sb_q.push_back(e);
    if (clr)      m_remap = 1'b0;  // R5 clear wins
    else if (set) m_remap = 1'b1;
  endtask

  task automatic do_reset(input logic pin);
    @(negedge clk_i);
    rst_i = 1'b1; boot_ext_i = pin; valid_i = 1'b0;
    remap_set_i = 1'b0; remap_clr_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_i = 1'b0;
    m_ext = pin;
    m_remap = 1'b0;
    boot_ext_i = ~pin;  // R3: late change must be ignored
    n_checks++;
    if (sel_o !== '0 || err_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 reset state: sel=%b err=%b expected sel=00000000 err=0",
               sel_o, err_o);
    end
  endtask

  // monitor: pops one expected item per cycle driven after reset
  always @(posedge clk_i) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (sel_o !== e.sel || err_o !== e.err) begin
        n_fail++;
        $display("FAIL %s: sel=%b err=%b expected sel=%b err=%b",
                 e.tag, sel_o, err_o, e.sel, e.err);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    cycle(1, 32'h0000_0100, 0, 0, "R1 R3 internal boot");
    cycle(1, 32'h000F_FFFC, 0, 0, "R1 top of boot window");
    cycle(1, 32'h0010_0000, 0, 0, "R6 rom alias region");
    cycle(1, 32'h0020_0040, 0, 0, "R6 sram region");
    cycle(1, 32'h1000_0800, 0, 0, "R7 small entry wins");
    cycle(1, 32'h1000_1000, 0, 0, "R7 large entry past small");
    cycle(1, 32'hF000_1234, 0, 0, "R6 peripheral region");
    cycle(1, 32'h3000_0000, 0, 0, "R8 unmapped high");
    cycle(1, 32'h0030_0000, 0, 0, "R8 unmapped low hole");
    cycle(0, 32'h0000_0000, 0, 0, "R9 idle cycle");
    cycle(1, 32'h0000_0004, 1, 0, "R10 decode with set uses old state");
    cycle(1, 32'h0000_0004, 0, 0, "R4 remapped to sram");
    cycle(1, 32'h0010_0000, 0, 0, "R6 table unchanged under remap");
    cycle(1, 32'h1FFF_FFFC, 0, 0, "R6 external region under remap");
    cycle(1, 32'h0000_0008, 1, 1, "R5 set and clear together");
    cycle(1, 32'h0000_0008, 0, 0, "R5 clear wins");
    cycle(1, 32'h0000_0000, 1, 0, "R10 set again");
    cycle(1, 32'h0000_0000, 0, 0, "R4 sram again");
    cycle(1, 32'h0000_0010, 0, 1, "R5 clear pulse");
    cycle(1, 32'h0000_0010, 0, 0, "R5 back to boot memory");
    cycle(1, 32'h0000_0000, 1, 0, "R5 set before reset");
    cycle(0, 32'h0000_0000, 0, 0, "R9 idle before reset");
    cycle(0, 32'h0000_0000, 0, 0, "R9 idle before reset");
    do_reset(1'b1);
    cycle(1, 32'h0000_0200, 0, 0, "R2 R5 external boot, reset cleared remap");
    cycle(1, 32'h0008_0000, 0, 0, "R3 pin change after reset ignored");
    cycle(1, 32'h0000_0200, 1, 0, "R10 set with external boot");
    cycle(1, 32'h0000_0200, 0, 0, "R4 sram regardless of pin");
    cycle(1, 32'hE000_0000, 0, 0, "R8 unmapped under remap");
    cycle(0, 32'h0000_0000, 0, 0, "R9 final idle");
    repeat (3) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule